// File: doc/BRIEF.md
# Serial DAC Input Register Controller

This block is the digital front end of a serial-input digital-to-analog converter. A host writes 16-bit words over three wires: an active-low frame strobe, a serial clock and a serial data line. The block moves these inputs into the system clock domain and shifts the bits in. When a word is complete, it updates an operating-mode register and a 14-bit code register. The analog side is represented by three registered outputs: the mode (normal drive or one of three power-down terminations), the parallel code, and a powered-up flag.

The two top bits of each word select the mode. The remaining fourteen bits carry the code. A power-down word changes only the mode, so the stored code survives while the output is terminated. A normal-mode word loads the mode and the code together. When the block leaves power-down, the powered-up flag stays low for a programmable number of system clocks. This models the time the analog stage needs to wake up. An incomplete word is dropped. Bits clocked after the sixteenth are ignored until the strobe is released.

Top module: `sdac_frontend`

## Requirements
- R1: After reset, code_o is 0, mode_o is 00 and powered_o is 1. These values hold until a complete 16-bit word has been received.
- R2: A word is 16 bits, most significant bit first. Each bit is taken at a falling edge of sclk while fsync_n is low.
- R3: Word bits 15:14 give the mode. The encoding is 00 normal, 01 power-down with 1 kΩ to ground, 10 power-down with 100 kΩ to ground, 11 power-down with the output in high impedance. mode_o presents the same code.
- R4: A word with mode 00 loads bits 13:0 into code_o. mode_o and code_o change in the same clock cycle. Neither changes in any cycle without a completed word.
- R5: A word with mode 01, 10 or 11 leaves code_o at its previous value. Its bits 13:0 are ignored.
- R6: fsync_n may stay low across a pause in sclk, for example between two 8-bit bursts. The bit count continues across the pause and does not restart.
- R7: If fsync_n rises before the sixteenth falling edge, the partial word is dropped. mode_o and code_o keep their values.
- R8: Falling edges of sclk after the sixteenth bit are ignored until fsync_n has risen.
- R9: powered_o is 0 whenever mode_o is not 00. After mode_o returns to 00 from a power-down mode, powered_o stays 0 for exactly WAKE_CYCLES clock cycles and then becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync_n | input | 1 | Active-low frame strobe, asynchronous to clk |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| mode_o | output | 2 | Operating mode: 00 normal, 01 1 kΩ, 10 100 kΩ, 11 high impedance |
| code_o | output | 14 | Stored DAC code |
| powered_o | output | 1 | High when the output stage is in normal mode and has woken up |

## Verification
The bench builds the block with the default 16-bit frame and a two-flop synchronizer. WAKE_CYCLES is set to 12, so the exact length of the powered-low window after leaving power-down can be counted in a few dozen clocks. The serial clock is slowed to eight system clocks per bit, which leaves the synchronizers ample margin. This makes it possible to reach the ordering cases: split bursts with a long idle gap, a strobe released early, and extra clocks after the sixteenth bit. It also covers power-down words that carry data which must not reach the code register.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE   = 2'b00,
    MODE_PD_LOW   = 2'b01,
    MODE_PD_HIGH  = 2'b10,
    MODE_PD_FLOAT = 2'b11
  } sdac_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fsync_s,
  input  logic                  sclk_s,
  input  logic                  sdin_s,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic                  sclk_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      cnt;
  logic                  fall;
  logic [FRAME_BITS-1:0] shifted;

  assign fall    = sclk_q & ~sclk_s;
  assign shifted = {shreg[FRAME_BITS-2:0], sdin_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_s;
      done_o <= 1'b0;
      if (fsync_s) begin
        cnt <= '0;
      end else if (fall && (cnt < CNT_W'(FRAME_BITS))) begin
        shreg <= shifted;
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(FRAME_BITS - 1)) begin
          done_o <= 1'b1;
          word_o <= shifted;
        end
      end
    end
  end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int MODE_BITS   = 2,
  parameter int WAKE_CYCLES = 20,
  localparam int CODE_BITS  = FRAME_BITS - MODE_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit_i,
  input  logic [FRAME_BITS-1:0] word_i,
  output logic [MODE_BITS-1:0]  mode_o,
  output logic [CODE_BITS-1:0]  code_o,
  output logic                  powered_o
);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic [MODE_BITS-1:0] new_mode, mode_n;
  logic [CODE_BITS-1:0] code_n;
  logic [WAKE_W-1:0]    wake_q, wake_n;
  logic                 new_active, cur_active, act_n;

  assign new_mode   = word_i[FRAME_BITS-1 -: MODE_BITS];
  assign new_active = (new_mode == MODE_BITS'(MODE_ACTIVE));
  assign cur_active = (mode_o == MODE_BITS'(MODE_ACTIVE));

  always_comb begin
    mode_n = mode_o;
    code_n = code_o;
    wake_n = (wake_q != '0) ? wake_q - 1'b1 : wake_q;
    if (commit_i) begin
      mode_n = new_mode;
      if (new_active) begin
        code_n = word_i[CODE_BITS-1:0];
        if (!cur_active) wake_n = WAKE_W'(WAKE_CYCLES);
      end
    end
    act_n = (mode_n == MODE_BITS'(MODE_ACTIVE));
    if (!act_n) wake_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o    <= MODE_BITS'(MODE_ACTIVE);
      code_o    <= '0;
      wake_q    <= '0;
      powered_o <= 1'b1;
    end else begin
      mode_o    <= mode_n;
      code_o    <= code_n;
      wake_q    <= wake_n;
      powered_o <= act_n && (wake_n == '0);
    end
  end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
  parameter int FRAME_BITS  = 16,
  parameter int MODE_BITS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 20,
  localparam int CODE_BITS  = FRAME_BITS - MODE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fsync_n,
  input  logic                 sclk,
  input  logic                 sdin,
  output logic [MODE_BITS-1:0] mode_o,
  output logic [CODE_BITS-1:0] code_o,
  output logic                 powered_o
);
  logic [2:0]            pins_s;
  logic                  frame_commit;
  logic [FRAME_BITS-1:0] frame_word;
  logic [MODE_BITS-1:0]  commit_mode;

  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d_i({fsync_n, sclk, sdin}), .q_o(pins_s)
  );

  sdac_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst(rst),
    .fsync_s(pins_s[2]), .sclk_s(pins_s[1]), .sdin_s(pins_s[0]),
    .done_o(frame_commit), .word_o(frame_word)
  );

  assign commit_mode = frame_word[FRAME_BITS-1 -: MODE_BITS];

  sdac_regs #(.FRAME_BITS(FRAME_BITS), .MODE_BITS(MODE_BITS),
              .WAKE_CYCLES(WAKE_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .commit_i(frame_commit), .word_i(frame_word),
    .mode_o(mode_o), .code_o(code_o), .powered_o(powered_o)
  );
endmodule

// File: rtl/sdac_checker.sv
module sdac_checker #(
  parameter int MODE_BITS = 2,
  parameter int CODE_BITS = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 commit,
  input logic [MODE_BITS-1:0] commit_mode,
  input logic [MODE_BITS-1:0] mode_o,
  input logic [CODE_BITS-1:0] code_o,
  input logic                 powered_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_o == '0 && mode_o == '0 && powered_o)) // R1
    else $error("reset state wrong");
  AST_QUIET_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(code_o) && $stable(mode_o))) // R4
    else $error("registers moved without a word");
  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
    (commit && commit_mode != '0) |=> $stable(code_o)) // R5
    else $error("power-down word changed code");
  AST_PD_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
    (mode_o != '0) |-> !powered_o) // R9
    else $error("powered in power-down");
  AST_EXIT_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) != '0 && mode_o == '0) |-> !powered_o) // R9
    else $error("no wake delay");
endmodule

bind sdac_frontend sdac_checker #(.MODE_BITS(MODE_BITS), .CODE_BITS(CODE_BITS)) u_chk (
  .clk(clk), .rst(rst), .commit(frame_commit), .commit_mode(commit_mode),
  .mode_o(mode_o), .code_o(code_o), .powered_o(powered_o)
);

// File: tb/tb_sdac_frontend.sv
module tb_sdac_frontend;
  localparam int WAKE = 12;
  localparam int HALF = 4;
  localparam int NV   = 7;
  localparam logic [15:0] FRAMES [NV] = '{16'h1234, 16'h3FFF, 16'h4AAA,
                                          16'h8555, 16'hC001, 16'h0000, 16'h2001};
  localparam logic [13:0] EXP_CODE [NV] = '{14'h1234, 14'h3FFF, 14'h3FFF,
                                            14'h3FFF, 14'h3FFF, 14'h0000, 14'h2001};

  logic clk = 0, rst = 1, fsync_n = 1, sclk = 1, sdin = 0;
  logic [1:0] mode_o;
  logic [13:0] code_o;
  logic powered_o;
  int tests = 0, fails = 0, lowcnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdac_frontend #(.WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rst(rst), .fsync_n(fsync_n), .sclk(sclk), .sdin(sdin),
    .mode_o(mode_o), .code_o(code_o), .powered_o(powered_o)
  );

  always @(negedge clk) if (mode_o == 2'b00 && !powered_o) lowcnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [31:0] val, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1; sdin = val[i]; wait_clk(HALF);
      sclk = 0; wait_clk(HALF);
    end
    sclk = 1;
  endtask

  task automatic send_frame(logic [15:0] w);
    fsync_n = 0; wait_clk(HALF);
    shift_bits({16'h0, w}, 16);
    wait_clk(HALF); fsync_n = 1; wait_clk(30);
  endtask

  initial begin
    wait_clk(5); rst = 0; wait_clk(3);
    // R1 reset state
    check("R1 code", code_o, 0); check("R1 mode", mode_o, 0); check("R1 powered", powered_o, 1);

    // R2 R3 R4 R5 table walk
    for (int k = 0; k < NV; k++) begin
      send_frame(FRAMES[k]);
      check("R3 mode", mode_o, FRAMES[k][15:14]);
      check("R2 R4 R5 code", code_o, EXP_CODE[k]);
      check("R9 powered", powered_o, FRAMES[k][15:14] == 2'b00);
    end

    // R7 partial word dropped
    fsync_n = 0; wait_clk(HALF); shift_bits(32'h23C, 10); wait_clk(HALF);
    fsync_n = 1; wait_clk(30);
    check("R7 code", code_o, 14'h2001); check("R7 mode", mode_o, 0);
    send_frame(16'h0777);
    check("R7 next word whole", code_o, 14'h0777);

    // R6 two bursts with a pause
    fsync_n = 0; wait_clk(HALF); shift_bits(32'h0A, 8); wait_clk(60);
    check("R6 no early update", code_o, 14'h0777);
    shift_bits(32'h5C, 8); wait_clk(HALF); fsync_n = 1; wait_clk(30);
    check("R6 code", code_o, 14'h0A5C);

    // R8 extra bits ignored
    fsync_n = 0; wait_clk(HALF); shift_bits(32'h1111F, 20); wait_clk(HALF);
    fsync_n = 1; wait_clk(30);
    check("R8 code", code_o, 14'h1111); check("R8 mode", mode_o, 0);

    // R9 wake window length
    send_frame(16'hC123);
    check("R5 code kept", code_o, 14'h1111); check("R9 pd low", powered_o, 0);
    lowcnt = 0;
    send_frame(16'h0456);
    check("R9 wake cycles", lowcnt, WAKE);
    check("R9 powered after", powered_o, 1); check("R4 code", code_o, 14'h0456);

    // R1 reset clears again
    rst = 1; wait_clk(3); rst = 0; wait_clk(2);
    check("R1 code after reset", code_o, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); tests++; fails++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule